// File: doc/BRIEF.md
# Register-Mapped GPIO Controller

This block controls 32 general-purpose pins through a small word-addressed register window on a single-cycle register bus. Each pin has a 3-bit function code, stored in one of four function-select words. The code makes the pin an input, an output, or one of six alternate functions. The current code of every pin is exported, so that an outside multiplexer can route real peripherals onto the pads. Pad muxing itself is not part of this block.

Software never writes the output levels directly. One register raises the output latches of the pins whose data bits are one, and a second register lowers them. Each operation is a single write with no read-modify-write, and pins whose bits are zero are untouched. A pin drives its pad only while its code selects plain output. Its latch keeps its value in every other mode. Every pad input passes through a two-flop synchronizer, and a level register reports the synchronized pin states.

Bus timing: a write takes effect at the clock edge where `bus_we` is high. Read data is registered. `bus_rdata` shows the register chosen by the `bus_addr` present at the previous edge. Addresses are byte offsets and are decoded exactly, so a misaligned offset is an unmapped offset.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every function code is 000, every output latch is 0, `pad_oe` is all zero and `bus_rdata` is zero.
- R2: A write to offset 0x00, 0x04, 0x08 or 0x0C (word w) loads pin p = 10*w + k from data bits [3k+2:3k] for k = 0..9. From the next cycle the new code appears on `pin_func[3p+2:3p]`. A read of the word returns the stored fields at the same bit positions. The function codes change only on such writes.
- R3: Code 000 selects input and code 001 selects output. `pad_oe[p]` is 1 exactly when pin p's code is 001.
- R4: The alternate codes are alt0=100, alt1=101, alt2=110, alt3=111, alt4=011 and alt5=010. Any of them is stored and exported unchanged, and it leaves `pad_oe` at 0 for that pin.
- R5: A write to offset 0x1C sets output latch p for each data bit p that is 1. Latches whose data bit is 0 are left unchanged.
- R6: A write to offset 0x28 clears output latch p for each data bit p that is 1. Latches whose data bit is 0 are left unchanged.
- R7: Reads of offsets 0x1C and 0x28 return zero.
- R8: `pad_out` always shows the output latches. A latch keeps its value while its pin is in a mode other than output, and it reappears driven when the pin returns to output mode.
- R9: Offset 0x34 reads pad levels through a two-flop synchronizer. For a pad change applied before clock edge E, reads whose address is presented at edges E and E+1 still return the old level, and a read presented at edge E+2 returns the new level.
- R10: Reads of any other offset in 0x00..0xFF, misaligned offsets included, return zero. Writes to such offsets change no function code and no latch.
- R11: Bits 31:30 of every function-select word read as zero, and so do the bits of word 0x0C above bit 5, which hold no pin. Writes of ones to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output latch value |
| pin_func | output | 96 | Per-pin 3-bit function code, pin p at bits [3p+2:3p] |

## Verification
The assertions assume that `rst` is held for at least one clock before normal operation. They also assume that `bus_we` and `bus_addr` are settled around each rising edge, so that a set or clear write is one clean cycle that the properties can link to the latch change. The bench changes bus signals and pad levels only on falling edges, keeps `bus_we` low during reset, and issues every access as a single-cycle pulse. It changes `pad_in` only when no level read is timing-critical, except in the latency sequence, where the change is deliberately placed right before a read.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int FSEL_W        = 3;
  localparam int PINS_PER_WORD = 10;

  localparam int OFS_FSEL  = 'h00;
  localparam int OFS_SET   = 'h1C;
  localparam int OFS_CLR   = 'h28;
  localparam int OFS_LEVEL = 'h34;

  typedef enum logic [FSEL_W-1:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT5   = 3'b010,
    FN_ALT4   = 3'b011,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111
  } pin_fn_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_fsel_bank.sv
`timescale 1ns/1ps
module gpio_fsel_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int NWORDS  = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
  localparam int SPARE   = DATA_W - PINS_PER_WORD * FSEL_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_PINS*FSEL_W-1:0] fsel_flat,
  output logic [NWORDS*DATA_W-1:0] word_flat
);
  logic [FSEL_W-1:0] fsel_q [NUM_PINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PINS; p++) fsel_q[p] <= FN_INPUT;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_addr == ADDR_W'(OFS_FSEL + 4 * (p / PINS_PER_WORD)))
          fsel_q[p] <= wr_data[(p % PINS_PER_WORD) * FSEL_W +: FSEL_W];
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_flat
    assign fsel_flat[p*FSEL_W +: FSEL_W] = fsel_q[p];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar s = 0; s < PINS_PER_WORD; s++) begin : g_slot
      if (w * PINS_PER_WORD + s < NUM_PINS) begin : g_used
        assign word_flat[w*DATA_W + s*FSEL_W +: FSEL_W] = fsel_q[w*PINS_PER_WORD + s];
      end else begin : g_empty
        assign word_flat[w*DATA_W + s*FSEL_W +: FSEL_W] = '0;
      end
    end
    if (SPARE > 0) begin : g_spare
      assign word_flat[w*DATA_W + PINS_PER_WORD*FSEL_W +: SPARE] = '0;
    end
  end

  if (SPARE > 0) begin : g_unused
    logic unused_spare_bits;
    assign unused_spare_bits = ^wr_data[DATA_W-1 -: SPARE];
  end
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] set_mask,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= (latch_q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/gpio_read_mux.sv
`timescale 1ns/1ps
module gpio_read_mux
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NWORDS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NWORDS*DATA_W-1:0] word_flat,
  input  logic [NUM_PINS-1:0]      level,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (rd_addr == ADDR_W'(OFS_FSEL + 4 * w)) rd_next = word_flat[w*DATA_W +: DATA_W];
    end
    if (rd_addr == ADDR_W'(OFS_LEVEL)) rd_next[NUM_PINS-1:0] = level;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_ctrl.sv
`timescale 1ns/1ps
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NWORDS  = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS*FSEL_W-1:0] pin_func
);
  logic [NWORDS*DATA_W-1:0] word_flat;
  logic [NUM_PINS-1:0]      level_sync;
  logic [NUM_PINS-1:0]      set_mask;
  logic [NUM_PINS-1:0]      clr_mask;

  gpio_fsel_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsel (
    .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .fsel_flat(pin_func), .word_flat(word_flat)
  );

  assign set_mask = (bus_we && bus_addr == ADDR_W'(OFS_SET)) ? bus_wdata[NUM_PINS-1:0] : '0;
  assign clr_mask = (bus_we && bus_addr == ADDR_W'(OFS_CLR)) ? bus_wdata[NUM_PINS-1:0] : '0;

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .latch_q(pad_out)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pad_oe[p] = (pin_func[p*FSEL_W +: FSEL_W] == FN_OUTPUT);
  end

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(level_sync)
  );

  gpio_read_mux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(bus_addr), .word_flat(word_flat),
    .level(level_sync), .rd_data(bus_rdata)
  );
endmodule

// File: rtl/gpio_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int NWORDS  = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_PINS-1:0]        pad_oe,
  input logic [NUM_PINS-1:0]        pad_out,
  input logic [NUM_PINS*FSEL_W-1:0] pin_func
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_out == '0 && pad_oe == '0 && pin_func == '0 && bus_rdata == '0)); // R1

  AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_we)) |-> $stable(pin_func)); // R2

  AST_OE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(pad_oe)) |-> $past(bus_we)); // R3

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_we && bus_addr == ADDR_W'(OFS_SET))) |->
      (((pad_out & $past(pad_out)) == $past(pad_out)) &&
       ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])))); // R5

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_we && bus_addr == ADDR_W'(OFS_CLR))) |->
      (((pad_out & ~$past(pad_out)) == '0) &&
       ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == '0))); // R6

  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(bus_addr) == ADDR_W'(OFS_SET) || $past(bus_addr) == ADDR_W'(OFS_CLR)))
      |-> (bus_rdata == '0)); // R7

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_we)) |-> $stable(pad_out)); // R8

  AST_FSEL_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) < ADDR_W'(4 * NWORDS)) |-> (bus_rdata[DATA_W-1 -: 2] == 2'b00)); // R11
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_out(pad_out), .pin_func(pin_func)
);

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe;
  logic [31:0] pad_out;
  logic [95:0] pin_func;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit rd_valid = 1'b0;

  logic [2:0]  exp_fsel [32];
  logic [31:0] exp_out = '0;
  logic [31:0] exp_q [$];
  string       req_q [$];

  always #2.5 clk = ~clk;

  gpio_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pin_func(pin_func)
  );

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_exp(int w);
    logic [31:0] r = '0;
    for (int s = 0; s < 10; s++) if (w * 10 + s < 32) r[s*3 +: 3] = exp_fsel[w*10 + s];
    return r;
  endfunction

  function automatic logic [95:0] func_exp();
    logic [95:0] r;
    for (int p = 0; p < 32; p++) r[p*3 +: 3] = exp_fsel[p];
    return r;
  endfunction

  function automatic logic [31:0] oe_exp();
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[p] = (exp_fsel[p] == 3'b001);
    return r;
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, logic [31:0] e, string req);
    bus_addr = a; bus_we = 1'b0;
    exp_q.push_back(e); req_q.push_back(req);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wr_fsel(int w, logic [31:0] v);
    bus_write(8'(4 * w), v);
    for (int s = 0; s < 10; s++) if (w * 10 + s < 32) exp_fsel[w*10 + s] = v[s*3 +: 3];
  endtask

  // scoreboard monitor
  initial begin
    bit taken;
    forever begin
      @(posedge clk);
      taken = rd_valid;
      @(negedge clk);
      if (taken) chk(req_q.pop_front(), 96'(bus_rdata), 96'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, lv_old, lv_new, snap_out;
    logic [95:0] snap_func;
    for (int p = 0; p < 32; p++) exp_fsel[p] = 3'b000;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pad_out", 96'(pad_out), 96'(0));
    chk("R1 pad_oe", 96'(pad_oe), 96'(0));
    chk("R1 pin_func", pin_func, 96'(0));
    chk("R1 rdata", 96'(bus_rdata), 96'(0));
    bus_read(8'h00, 32'h0, "R1 fsel0");

    // R2 R3 R4 word 0 with every code, spare bits set (R11)
    w0 = {2'b11, 3'b001, 3'b000, 3'b001, 3'b010, 3'b011, 3'b111, 3'b110, 3'b101, 3'b100, 3'b001};
    wr_fsel(0, w0);
    chk("R4 pin_func alt codes", pin_func, func_exp());
    chk("R3 pad_oe", 96'(pad_oe), 96'(oe_exp()));
    chk("R3 oe pins 0 7 9", 96'(pad_oe), 96'(32'h0000_0281));
    bus_read(8'h00, word_exp(0), "R2 fsel0 readback");
    bus_read(8'h00, w0 & 32'h3FFF_FFFF, "R11 fsel0 spare bits");

    wr_fsel(1, 32'h0924_9249);
    wr_fsel(2, 32'h1234_5678);
    wr_fsel(3, 32'hFFFF_FFFF);
    bus_read(8'h04, 32'h0924_9249, "R2 fsel1");
    bus_read(8'h08, 32'h1234_5678 & 32'h3FFF_FFFF, "R2 fsel2");
    bus_read(8'h0C, 32'h0000_003F, "R11 fsel3 empty fields");
    chk("R2 pin_func all words", pin_func, func_exp());
    chk("R3 pad_oe all words", 96'(pad_oe), 96'(oe_exp()));

    // R5 set register
    bus_write(8'h1C, 32'h0000_0481); exp_out |= 32'h0000_0481;
    chk("R5 set bits 0 7 10", 96'(pad_out), 96'(exp_out));
    bus_write(8'h1C, 32'h0000_0002); exp_out |= 32'h0000_0002;
    chk("R5 zero bits keep", 96'(pad_out), 96'(exp_out));
    bus_read(8'h1C, 32'h0, "R7 set reads zero");
    bus_read(8'h28, 32'h0, "R7 clr reads zero");

    // R6 clear register
    bus_write(8'h28, 32'h0000_0001); exp_out &= ~32'h0000_0001;
    chk("R6 clear bit 0", 96'(pad_out), 96'(exp_out));
    bus_write(8'h28, 32'h0000_0000);
    chk("R6 zero clears nothing", 96'(pad_out), 96'(exp_out));

    // R8 latch persists across mode changes
    chk("R8 alt pin1 latch high oe low", 96'({pad_out[1], pad_oe[1]}), 96'(2'b10));
    wr_fsel(0, word_exp(0) & ~(32'h7 << 21));
    chk("R8 pin7 input oe", 96'(pad_oe[7]), 96'(0));
    chk("R8 pin7 input latch", 96'(pad_out), 96'(exp_out));
    wr_fsel(0, word_exp(0) | (32'h1 << 21));
    chk("R8 pin7 output again", 96'({pad_out[7], pad_oe[7]}), 96'(2'b11));

    // R9 level register latency
    lv_old = 32'hA5A5_5A5A;
    pad_in = lv_old;
    repeat (4) @(negedge clk);
    bus_read(8'h34, lv_old, "R9 level steady");
    lv_new = 32'h0F0F_F0F1;
    pad_in = lv_new;
    bus_read(8'h34, lv_old, "R9 level edge E");
    bus_read(8'h34, lv_old, "R9 level edge E+1");
    bus_read(8'h34, lv_new, "R9 level edge E+2");

    // R10 unmapped offsets
    snap_out = pad_out; snap_func = pin_func;
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h2C, 32'hFFFF_FFFF);
    bus_write(8'h1D, 32'hFFFF_FFFF);
    bus_write(8'h29, 32'hFFFF_FFFF);
    bus_write(8'h01, 32'h0000_0000);
    bus_write(8'hB4, 32'hFFFF_FFFF);
    chk("R10 latch untouched", 96'(pad_out), 96'(snap_out));
    chk("R10 func untouched", pin_func, snap_func);
    bus_read(8'h10, 32'h0, "R10 read 0x10");
    bus_read(8'h38, 32'h0, "R10 read 0x38");
    bus_read(8'h35, 32'h0, "R10 read misaligned");
    bus_read(8'hB4, 32'h0, "R10 read 0xB4");
    bus_read(8'h04, 32'h0924_9249, "R10 fsel1 intact");
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule